// File: doc/BRIEF.md
# Trace Cache with Line-Fill Buffer

This block sits in an instruction-fetch front end and holds up to 64 dynamic traces, each a run of up to 16 instructions that may span several basic blocks and contain up to three conditional branches. A lookup presents a fetch address together with one prediction bit per upcoming branch. A line answers when its start address equals the fetch address and its recorded branch directions agree with the predictions. On such a hit it returns the whole trace and the address to fetch next. When the address matches but a direction disagrees, only the instructions up to and including the first disagreeing branch are returned.

Traces are built by a fill buffer. It is fed basic blocks from the ordinary fetch path, one block per cycle when `blk_valid` is high, and concatenates them. It closes the current trace when the next block would not fit, or when a block ends in an indirect jump or return. A closed trace is written into its direct-mapped line one cycle later and replaces whatever that line held.

A trace ending in a conditional branch keeps that branch as its terminal branch. The terminal branch's direction is not recorded in the hit check. Instead, its prediction picks between the stored taken target and the stored fall-through address.

Top module: `trace_cache`

## Requirements
- R1: After reset no line is valid, so every lookup misses (`rsp_hit`=0, `rsp_partial`=0, `rsp_len`=0) until a trace has been written.
- R2: A lookup sampled at a rising edge with `lk_valid`=1 is answered on the outputs after that same edge. A cycle without a lookup gives `rsp_hit`=0, `rsp_partial`=0, `rsp_len`=0, `rsp_insns`=0 and `rsp_next`=0.
- R3: The line index is `lk_addr[7:2]`. A line matches only if its stored start address equals `lk_addr`, so an address with the same index but different upper bits misses.
- R4: On a full hit, `rsp_hit`=1 and `rsp_len` is the trace length. The instructions appear in trace order, with slot i at `rsp_insns[32*i +: 32]`, and slots at or above `rsp_len` read zero.
- R5: The next address is chosen as follows. For a line whose last block ends in a conditional branch (the terminal branch, number n-1 of n), `rsp_next` is the taken target when `lk_pred[n-1]`=1 and the fall-through address otherwise. For any other line it is the fall-through address of the last block. `rsp_next` is 0 whenever `rsp_hit`=0.
- R6: When the address matches but compared branch k (the lowest such index) disagrees with `lk_pred[k]`, the block outputs `rsp_partial`=1, `rsp_hit`=0 and `rsp_len`=(position of branch k)+1. Slots from `rsp_len` upward read zero.
- R7: Branch k of a trace, in trace order, is compared with `lk_pred[k]`. Only the recorded branches are compared, which excludes the terminal branch. Prediction bits at or beyond that count have no effect.
- R8: Each accepted block is appended to the trace in the fill buffer. If appending it would exceed 16 instructions or 3 branches, the buffered trace is closed and the block starts a new one. A total of exactly 16 instructions still fits.
- R9: A block with `blk_indirect`=1 is appended and then closes the trace, so it is part of that trace. The trace's next address is that block's `blk_fall`.
- R10: A trace closed at edge T is written at edge T+1 into line `start[7:2]`, replacing the previous content. A lookup sampled at T+1 still sees the old line, and one sampled at T+2 or later sees the new trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Fetch address to look up |
| lk_pred | input | 3 | Predicted direction per branch, bit k for branch k, 1 = taken |
| rsp_hit | output | 1 | Full trace hit |
| rsp_partial | output | 1 | Address matched, trace cut at first disagreeing branch |
| rsp_len | output | 5 | Number of instructions delivered |
| rsp_insns | output | 512 | Delivered instructions, slot i at bits 32*i+31..32*i |
| rsp_next | output | 32 | Next fetch address on a full hit |
| blk_valid | input | 1 | Basic block offered to the fill buffer |
| blk_addr | input | 32 | Start address of the block |
| blk_len | input | 5 | Instructions in the block, 1 to 16 |
| blk_insns | input | 512 | Block instructions, slot i at bits 32*i+31..32*i; slots at or above blk_len ignored |
| blk_cond | input | 1 | Block ends in a conditional branch (its last instruction) |
| blk_taken | input | 1 | Resolved direction of that branch |
| blk_indirect | input | 1 | Block ends in an indirect jump or return |
| blk_target | input | 32 | Taken target of the ending branch |
| blk_fall | input | 32 | Address following the block on its not-taken or resolved path |

## Verification
The checks take for granted that every offered block holds between 1 and 16 instructions. They also assume that a block's conditional branch, when present, is its last instruction, and that no block is both conditional and indirect. They rely on traces always being at least one instruction long, so a hit or partial result never reports zero length. The stimulus respects all of this: it offers only word-aligned addresses and legal lengths, and it drives every input on the falling edge. It spaces each closing block and the lookup that should see the trace by the one-cycle write delay, except where it deliberately checks that delay.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int ADDR_W     = 32;
  localparam int INSN_W     = 32;
  localparam int MAX_INSN   = 16;
  localparam int MAX_BR     = 3;
  localparam int LINES      = 64;
  localparam int INSN_BYTES = 4;

  localparam int OFF_W = $clog2(INSN_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int LEN_W = $clog2(MAX_INSN + 1);
  localparam int POS_W = $clog2(MAX_INSN);
  localparam int NBR_W = $clog2(MAX_BR + 1);
  localparam int VEC_W = MAX_INSN * INSN_W;

  typedef logic [VEC_W-1:0] insn_vec_t;

  // One stored trace: start address, size, branch bookkeeping and successors.
  typedef struct packed {
    logic [ADDR_W-1:0]       start;
    logic [LEN_W-1:0]        len;
    logic [NBR_W-1:0]        nbr;    // all branches, terminal included
    logic [MAX_BR-1:0]       flags;  // recorded direction per branch
    logic [MAX_BR*POS_W-1:0] pos;    // slot of each branch
    logic                    term;   // last block ends in a conditional branch
    logic [ADDR_W-1:0]       fall;
    logic [ADDR_W-1:0]       target;
    insn_vec_t               insns;
  } trace_t;

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
endpackage

// File: rtl/tc_fill.sv
module tc_fill
  import tcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_valid,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  insn_vec_t         blk_insns,
  input  logic              blk_cond,
  input  logic              blk_taken,
  input  logic              blk_indirect,
  input  logic [ADDR_W-1:0] blk_target,
  input  logic [ADDR_W-1:0] blk_fall,
  output logic              wr_v,
  output trace_t            wr_q
);
  trace_t buf_q;
  trace_t merged;
  logic   buf_act;
  logic   buf_done;   // buffered trace already closed, waits for the write stage
  logic   base_act;
  logic   ovf;
  logic   busy;

  always_comb begin
    int off;
    int blen;
    base_act = buf_act && !buf_done;
    blen     = int'(blk_len);
    ovf = base_act &&
          ((int'(buf_q.len) + blen > MAX_INSN) ||
           (int'(buf_q.nbr) + int'(blk_cond) > MAX_BR));
    busy = buf_done || (blk_valid && ovf);

    if (!base_act || ovf) begin
      merged       = '0;
      merged.start = blk_addr;
      off          = 0;
    end else begin
      merged = buf_q;
      off    = int'(buf_q.len);
    end

    for (int i = 0; i < MAX_INSN; i++) begin
      if (i >= off && i < off + blen)
        merged.insns[i*INSN_W +: INSN_W] = blk_insns[(i-off)*INSN_W +: INSN_W];
    end

    if (blk_cond) begin
      merged.flags[merged.nbr] = blk_taken;
      merged.pos[int'(merged.nbr)*POS_W +: POS_W] = POS_W'(off + blen - 1);
    end
    merged.nbr    = merged.nbr + NBR_W'(blk_cond);
    merged.len    = LEN_W'(off + blen);
    merged.term   = blk_cond;
    merged.fall   = blk_fall;
    merged.target = blk_cond ? blk_target : blk_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      buf_act  <= 1'b0;
      buf_done <= 1'b0;
      wr_v     <= 1'b0;
      wr_q     <= '0;
    end else begin
      wr_v <= 1'b0;
      if (buf_done) begin
        wr_q     <= buf_q;
        wr_v     <= 1'b1;
        buf_q    <= '0;
        buf_act  <= 1'b0;
        buf_done <= 1'b0;
      end
      if (blk_valid) begin
        if (ovf) begin
          wr_q <= buf_q;
          wr_v <= 1'b1;
        end
        if (blk_indirect && !busy) begin
          wr_q     <= merged;
          wr_v     <= 1'b1;
          buf_q    <= '0;
          buf_act  <= 1'b0;
          buf_done <= 1'b0;
        end else begin
          buf_q    <= merged;
          buf_act  <= 1'b1;
          buf_done <= blk_indirect;
        end
      end
    end
  end
endmodule

// File: rtl/tc_store.sv
module tc_store
  import tcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_v,
  input  trace_t           wr_line,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output trace_t           rd_line
);
  trace_t             mem [LINES];
  logic [LINES-1:0]   vld;
  logic [IDX_W-1:0]   wr_idx;

  assign wr_idx = line_idx(wr_line.start);

  always_ff @(posedge clk) begin
    if (wr_v) mem[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rst)       vld <= '0;
    else if (wr_v) vld[wr_idx] <= 1'b1;
  end

  assign rd_line  = mem[rd_idx];
  assign rd_valid = vld[rd_idx];
endmodule

// File: rtl/tc_match.sv
module tc_match
  import tcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [MAX_BR-1:0] lk_pred,
  input  logic              rd_valid,
  input  trace_t            rd_line,
  output logic              rsp_hit,
  output logic              rsp_partial,
  output logic [LEN_W-1:0]  rsp_len,
  output insn_vec_t         rsp_insns,
  output logic [ADDR_W-1:0] rsp_next
);
  logic              addr_ok;
  logic              any_mis;
  logic              full;
  logic              part;
  logic [NBR_W-1:0]  first;
  logic [ADDR_W-1:0] nxt;
  int                dlen;
  insn_vec_t         masked;

  always_comb begin
    int ncmp;
    addr_ok = lk_valid && rd_valid && (rd_line.start == lk_addr);
    ncmp    = int'(rd_line.nbr) - int'(rd_line.term);
    any_mis = 1'b0;
    first   = '0;
    for (int k = MAX_BR - 1; k >= 0; k--) begin
      if (k < ncmp && lk_pred[k] != rd_line.flags[k]) begin
        any_mis = 1'b1;
        first   = NBR_W'(k);
      end
    end
    full = addr_ok && !any_mis;
    part = addr_ok && any_mis;
    if (full)      dlen = int'(rd_line.len);
    else if (part) dlen = int'(rd_line.pos[int'(first)*POS_W +: POS_W]) + 1;
    else           dlen = 0;
    if (rd_line.term && lk_pred[rd_line.nbr - NBR_W'(1)]) nxt = rd_line.target;
    else                                                   nxt = rd_line.fall;
  end

  for (genvar g = 0; g < MAX_INSN; g++) begin : g_mask
    assign masked[g*INSN_W +: INSN_W] = (g < dlen) ? rd_line.insns[g*INSN_W +: INSN_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit     <= 1'b0;
      rsp_partial <= 1'b0;
      rsp_len     <= '0;
      rsp_insns   <= '0;
      rsp_next    <= '0;
    end else begin
      rsp_hit     <= full;
      rsp_partial <= part;
      rsp_len     <= LEN_W'(dlen);
      rsp_insns   <= masked;
      rsp_next    <= full ? nxt : '0;
    end
  end
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [MAX_BR-1:0] lk_pred,
  output logic              rsp_hit,
  output logic              rsp_partial,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [VEC_W-1:0]  rsp_insns,
  output logic [ADDR_W-1:0] rsp_next,
  input  logic              blk_valid,
  input  logic [ADDR_W-1:0] blk_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [VEC_W-1:0]  blk_insns,
  input  logic              blk_cond,
  input  logic              blk_taken,
  input  logic              blk_indirect,
  input  logic [ADDR_W-1:0] blk_target,
  input  logic [ADDR_W-1:0] blk_fall
);
  logic   wr_v;
  trace_t wr_q;
  logic   rd_valid;
  trace_t rd_line;

  tc_fill u_fill (
    .clk(clk), .rst(rst),
    .blk_valid(blk_valid), .blk_addr(blk_addr), .blk_len(blk_len),
    .blk_insns(blk_insns), .blk_cond(blk_cond), .blk_taken(blk_taken),
    .blk_indirect(blk_indirect), .blk_target(blk_target), .blk_fall(blk_fall),
    .wr_v(wr_v), .wr_q(wr_q)
  );

  tc_store u_store (
    .clk(clk), .rst(rst), .wr_v(wr_v), .wr_line(wr_q),
    .rd_idx(line_idx(lk_addr)), .rd_valid(rd_valid), .rd_line(rd_line)
  );

  tc_match u_match (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_pred(lk_pred), .rd_valid(rd_valid), .rd_line(rd_line),
    .rsp_hit(rsp_hit), .rsp_partial(rsp_partial), .rsp_len(rsp_len),
    .rsp_insns(rsp_insns), .rsp_next(rsp_next)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import tcf_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             rsp_hit,
  input logic             rsp_partial,
  input logic [LEN_W-1:0] rsp_len,
  input logic             blk_valid,
  input logic [LEN_W-1:0] blk_len,
  input logic             wr_en
);
  logic any_wr;

  always_ff @(posedge clk) begin
    if (rst)        any_wr <= 1'b0;
    else if (wr_en) any_wr <= 1'b1;
  end

  // R1: nothing can hit before the first trace write after reset
  p_cold_miss_r1: assert property (@(posedge clk) disable iff (rst)
    !any_wr |-> (!rsp_hit && !rsp_partial));

  // R2: a cycle without a lookup yields an empty response
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_hit && !rsp_partial && rsp_len == '0));

  // R6: full and partial results never coincide
  p_hit_part_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_partial));

  // R4: a full hit delivers at least one instruction
  p_hit_len_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_len != '0);

  // R6: a partial result delivers at least the first branch slot
  p_part_len_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_partial |-> rsp_len != '0);

  // R8: offered blocks stay within the legal length range
  p_blk_len_r8: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> (blk_len != '0 && int'(blk_len) <= MAX_INSN));
endmodule

bind trace_cache tc_checker u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .rsp_hit(rsp_hit),
  .rsp_partial(rsp_partial), .rsp_len(rsp_len), .blk_valid(blk_valid),
  .blk_len(blk_len), .wr_en(wr_v)
);

// File: tb/trace_cache_test.sv
module trace_cache_test;
  import tcf_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [MAX_BR-1:0] lk_pred = '0;
  logic              rsp_hit, rsp_partial;
  logic [LEN_W-1:0]  rsp_len;
  logic [VEC_W-1:0]  rsp_insns;
  logic [ADDR_W-1:0] rsp_next;
  logic              blk_valid = 1'b0;
  logic [ADDR_W-1:0] blk_addr = '0;
  logic [LEN_W-1:0]  blk_len = '0;
  logic [VEC_W-1:0]  blk_insns = '0;
  logic              blk_cond = 1'b0, blk_taken = 1'b0, blk_indirect = 1'b0;
  logic [ADDR_W-1:0] blk_target = '0, blk_fall = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_cache uut (.*);

  function automatic insn_vec_t words(input logic [31:0] a, input int n, input int at);
    insn_vec_t v = '0;
    for (int j = 0; j < n; j++) v[(at+j)*INSN_W +: INSN_W] = a + 32'(4*j);
    return v;
  endfunction

  task automatic check(input string req, input string what, input insn_vec_t act, input insn_vec_t exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_blk(input logic [31:0] a, input int n, input bit c, input bit t,
                          input bit ind, input logic [31:0] tgt, input logic [31:0] fl);
    blk_valid = 1'b1; blk_addr = a; blk_len = LEN_W'(n); blk_insns = words(a, n, 0);
    blk_cond = c; blk_taken = t; blk_indirect = ind; blk_target = tgt; blk_fall = fl;
    @(negedge clk);
    blk_valid = 1'b0; blk_cond = 1'b0; blk_indirect = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [2:0] p);
    lk_valid = 1'b1; lk_addr = a; lk_pred = p;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input bit h, input bit pt, input int n,
                            input insn_vec_t ins, input logic [31:0] nx);
    check(req, "hit", insn_vec_t'(rsp_hit), insn_vec_t'(h));
    check(req, "partial", insn_vec_t'(rsp_partial), insn_vec_t'(pt));
    check(req, "len", insn_vec_t'(rsp_len), insn_vec_t'(n));
    check(req, "insns", rsp_insns, ins);
    check(req, "next", insn_vec_t'(rsp_next), insn_vec_t'(nx));
  endtask

  task automatic t_reset();
    check("R1", "reset hit", insn_vec_t'(rsp_hit), '0);
    lookup(32'h0000_1040, 3'b000);
    expect_rsp("R1", 0, 0, 0, '0, 0);
  endtask

  // Trace A: three branch-ending blocks, closed when a fourth branch would not fit.
  task automatic t_trace_a();
    insn_vec_t ea = words(32'h1040, 4, 0) | words(32'h2000, 5, 4) | words(32'h2014, 3, 9);
    send_blk(32'h1040, 4, 1, 1, 0, 32'h2000, 32'h1050);
    send_blk(32'h2000, 5, 1, 0, 0, 32'h3000, 32'h2014);
    send_blk(32'h2014, 3, 1, 1, 0, 32'h4000, 32'h2020);
    send_blk(32'h4080, 2, 1, 1, 0, 32'h5000, 32'h4088);  // R8 overflow on branch count
    idle(2);
    lookup(32'h1040, 3'b001);
    expect_rsp("R4", 1, 0, 12, ea, 32'h2020);             // R5 terminal predicted not taken
    lookup(32'h1040, 3'b101);
    expect_rsp("R5", 1, 0, 12, ea, 32'h4000);             // R7 terminal bit not compared
    lookup(32'h1040, 3'b011);
    expect_rsp("R6", 0, 1, 9, words(32'h1040, 4, 0) | words(32'h2000, 5, 4), 0);
    lookup(32'h1040, 3'b000);
    expect_rsp("R6", 0, 1, 4, words(32'h1040, 4, 0), 0);
    lookup(32'h5040, 3'b001);
    expect_rsp("R3", 0, 0, 0, '0, 0);
  endtask

  // Trace B: one recorded branch, closed by an indirect block.
  task automatic t_trace_b();
    insn_vec_t eb = words(32'h4080, 2, 0) | words(32'h5000, 3, 2);
    send_blk(32'h5000, 3, 0, 0, 1, 32'h0, 32'h9000);
    idle(2);
    lookup(32'h4080, 3'b001);
    expect_rsp("R9", 1, 0, 5, eb, 32'h9000);
    lookup(32'h4080, 3'b111);
    expect_rsp("R7", 1, 0, 5, eb, 32'h9000);
    lookup(32'h4080, 3'b110);
    expect_rsp("R7", 0, 1, 2, words(32'h4080, 2, 0), 0);
    @(negedge clk);
    expect_rsp("R2", 0, 0, 0, '0, 0);
  endtask

  // Trace C: exactly 16 instructions fit, the 17th opens a new trace.
  task automatic t_trace_c();
    insn_vec_t ec = words(32'h6000, 10, 0) | words(32'h6028, 6, 10);
    send_blk(32'h6000, 10, 0, 0, 0, 32'h0, 32'h6028);
    send_blk(32'h6028, 6, 0, 0, 0, 32'h0, 32'h6040);
    send_blk(32'h6040, 1, 0, 0, 0, 32'h0, 32'h7000);
    idle(2);
    lookup(32'h6000, 3'b111);
    expect_rsp("R8", 1, 0, 16, ec, 32'h6040);
  endtask

  // Trace D shares trace A's line; checks the write delay and replacement.
  task automatic t_trace_d();
    insn_vec_t ed = words(32'h6040, 1, 0) | words(32'h7000, 2, 1);
    send_blk(32'h7000, 2, 0, 0, 1, 32'h0, 32'h7100);
    lookup(32'h6040, 3'b000);
    expect_rsp("R10", 0, 0, 0, '0, 0);
    lookup(32'h6040, 3'b000);
    expect_rsp("R10", 1, 0, 3, ed, 32'h7100);
    lookup(32'h1040, 3'b001);
    expect_rsp("R10", 0, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_trace_a();
    t_trace_b();
    t_trace_c();
    t_trace_d();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule